// File: doc/BRIEF.md
# Single-Channel Byte Mover with Early End Strobe

This block is one channel of a direct-memory-access engine. It copies bytes between a fixed peripheral data address and a memory buffer, one byte for each request the peripheral raises. For every request it serves, it performs one read and then one write on a simple single-beat bus, counts down the bytes that remain and moves the memory pointer forward. The peripheral address never changes.

Software loads the peripheral address, the buffer address and the byte count, then sets the enable bit in the control register. That register also holds the direction, a two-bit priority that an outside arbiter can use, and separate interrupt enables for the half-way point and for completion. Two strobes go back to the peripheral. The early strobe comes with the transfer that leaves one byte, so the peripheral can prepare its final byte. The final strobe comes with the last transfer. When the count reaches zero the channel goes quiet. It stays quiet until software clears the enable bit and sets it again.

Top module: `dma_chan_top`

## Requirements
- R1: After reset, bus_req, periph_ack, eot_early, eot_final, half_flag, full_flag and irq are low, and xfer_left is zero.
- R2: The control register is at select 3: bit 0 is enable, bit 1 is direction, bit 2 is the half-point interrupt enable, bit 3 is the completion interrupt enable, and bits 5:4 are priority. Select 0 is the peripheral address, select 1 is the buffer address and select 2 is the count. A write that changes enable from 0 to 1 starts a run: two clock edges later xfer_left equals the programmed count and both flags are clear.
- R3: Each serviced request makes exactly one bus read and then one bus write, and the write carries the byte that was read. With direction 0 the read is at the peripheral address and the write is at the buffer pointer. With direction 1 the read is at the buffer pointer and the write is at the peripheral address.
- R4: The buffer pointer starts at the programmed buffer address and increases by one after each transfer. The peripheral address stays the same.
- R5: Each serviced request raises periph_ack for exactly one cycle, and xfer_left drops by one on the following clock edge.
- R6: eot_early is high together with periph_ack of the transfer that leaves one byte remaining. It never fires when the programmed count is 1.
- R7: eot_final is high together with periph_ack of the transfer that leaves zero bytes, and at no other time.
- R8: half_flag sets when the remaining count becomes the programmed count divided by two, rounded down. full_flag sets when the remaining count reaches zero. Both flags hold until the next start. irq is the OR of each flag gated by its own interrupt enable.
- R9: While xfer_left is zero, including a start with a count of zero, requests cause no bus activity and no periph_ack.
- R10: While enable is set, writes to the address and count registers are ignored, and a control write changes only the enable bit.
- R11: chan_prio always equals control bits 5:4.
- R12: While enable is clear, requests cause no bus activity and no periph_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | CFG_W | Register write data |
| chan_prio | output | 2 | Configured priority, for an outside arbiter |
| periph_req | input | 1 | Peripheral transfer request (level) |
| periph_ack | output | 1 | One-cycle pulse when a request has been served |
| eot_early | output | 1 | Strobe with the transfer that leaves one byte |
| eot_final | output | 1 | Strobe with the last transfer |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data |
| bus_ack | input | 1 | Bus access complete |
| xfer_left | output | CNT_W | Remaining transfer count |
| half_flag | output | 1 | Half-point reached |
| full_flag | output | 1 | All transfers done |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks the strobes one transfer at a time on runs of four, three and one byte. A design off by one in its count compare would fire the early strobe one transfer late, or would fire it on a one-byte run. For the half point it uses an even count and an odd count, so that rounding up, or setting the flag one transfer too early, shows up in the flag. It also sends requests after the count has run out, after a start with a count of zero, and while the channel is disabled. A channel that did not stop would make extra bus accesses and would wrap its count. Finally it writes the count, the addresses and the direction while a run is active: any design that took those writes would change xfer_left or move the next bus addresses off their expected sequence.

// File: rtl/dma_pkg.sv
// Shared types and register map for the byte-mover channel.
// Assumes a two-bit register select and a six-bit control field.
package dma_pkg;
    localparam logic [1:0] SEL_PADDR = 2'd0;
    localparam logic [1:0] SEL_MADDR = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;
    localparam logic [1:0] SEL_CTRL  = 2'd3;
    localparam int CTRL_W = 6;

    // Control field, bit 0 (en) up to bits 5:4 (prio).
    typedef struct packed {
        logic [1:0] prio;
        logic       full_ie;
        logic       half_ie;
        logic       dir;
        logic       en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_FIN  = 2'd3
    } xfer_st_t;
endpackage

// File: rtl/dma_cfg_regs.sv
// Configuration registers for one channel.
// Holds the peripheral address, the buffer address, the count and the control field.
// While the channel is enabled, every field except enable is frozen.
// Emits a one-cycle start pulse when enable goes from 0 to 1.
// Assumes CFG_W >= ADDR_W, CNT_W and CTRL_W.
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [ADDR_W-1:0] paddr,
    output logic [ADDR_W-1:0] maddr,
    output logic [CNT_W-1:0]  count,
    output ctrl_t             ctrl,
    output logic              start
);
    logic [ADDR_W-1:0] paddr_q, maddr_q;
    logic [CNT_W-1:0]  count_q;
    ctrl_t             ctrl_q;
    logic              start_q;

    // Register writes, gated by the enable state, and start pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            maddr_q <= '0;
            count_q <= '0;
            ctrl_q  <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (cfg_we) begin
                case (cfg_sel)
                    SEL_PADDR: if (!ctrl_q.en) paddr_q <= cfg_wdata[ADDR_W-1:0];
                    SEL_MADDR: if (!ctrl_q.en) maddr_q <= cfg_wdata[ADDR_W-1:0];
                    SEL_COUNT: if (!ctrl_q.en) count_q <= cfg_wdata[CNT_W-1:0];
                    default: begin
                        if (ctrl_q.en) begin
                            ctrl_q.en <= cfg_wdata[0];
                        end else begin
                            ctrl_q  <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                            start_q <= cfg_wdata[0];
                        end
                    end
                endcase
            end
        end
    end

    assign paddr = paddr_q;
    assign maddr = maddr_q;
    assign count = count_q;
    assign ctrl  = ctrl_q;
    assign start = start_q;

    // R10: setup fields hold while the channel is enabled
    a_r10_frozen_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.en |=> ($stable(paddr_q) && $stable(maddr_q) && $stable(count_q)
                       && $stable(ctrl_q.dir) && $stable(ctrl_q.prio)));

    // R2: start pulse only arises from a disabled channel
    a_r2_start_from_off: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> ($past(!ctrl_q.en) && ctrl_q.en));
endmodule

// File: rtl/dma_xfer_fsm.sv
// Bus sequencer: serves one peripheral request with a read beat and then a write beat.
// The source and destination come from the direction bit.
// The state is sampled between transfers only, so a disable lets the current transfer finish.
// Assumes the bus slave raises bus_ack for one cycle for each access.
module dma_xfer_fsm
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              periph_req,
    input  logic              dir,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [ADDR_W-1:0] cursor,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              step
);
    xfer_st_t          st_q, st_d;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] src_addr, dst_addr;

    assign src_addr = dir ? cursor : paddr;
    assign dst_addr = dir ? paddr  : cursor;

    // Next-state selection for the read/write/finish sequence.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (active && periph_req) st_d = ST_RD;
            ST_RD:   if (bus_ack) st_d = ST_WR;
            ST_WR:   if (bus_ack) st_d = ST_FIN;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register, plus a latch for the byte fetched in the read beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            data_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_RD && bus_ack) data_q <= bus_rdata;
        end
    end

    // Bus drive decoded from the state.
    always_comb begin
        bus_req   = (st_q == ST_RD) || (st_q == ST_WR);
        bus_we    = (st_q == ST_WR);
        bus_addr  = (st_q == ST_WR) ? dst_addr : src_addr;
        bus_wdata = data_q;
    end

    assign step = (st_q == ST_FIN);

    // R3: an acknowledged read is always followed by a write beat
    a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ack) |=> (bus_req && bus_we));

    // R3: an acknowledged write completes the transfer
    a_r3_write_ends_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_ack) |=> (step && !bus_req));
endmodule

// File: rtl/dma_progress.sv
// Progress tracker: remaining count, buffer pointer, half and full flags, end strobes.
// Loaded on start. Advanced once for each finished transfer (step).
// Assumes step never arrives while the count is zero.
module dma_progress #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] maddr,
    input  logic              step,
    output logic [CNT_W-1:0]  left,
    output logic [ADDR_W-1:0] cursor,
    output logic              half_flag,
    output logic              full_flag,
    output logic              early,
    output logic              final_x
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0]  left_q, total_q, rem_next;
    logic [ADDR_W-1:0] cur_q;
    logic              half_q, full_q, half_hit;

    assign rem_next = left_q - ONE;
    // Remaining equals floor(total/2), written as 2*rem == total or 2*rem+1 == total.
    assign half_hit = ({rem_next, 1'b0} == {1'b0, total_q}) ||
                      ({rem_next, 1'b1} == {1'b0, total_q});

    // Count, pointer and flag update on start and on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            total_q <= '0;
            cur_q   <= '0;
            half_q  <= 1'b0;
            full_q  <= 1'b0;
        end else if (start) begin
            left_q  <= count;
            total_q <= count;
            cur_q   <= maddr;
            half_q  <= 1'b0;
            full_q  <= 1'b0;
        end else if (step) begin
            left_q <= rem_next;
            cur_q  <= cur_q + ADDR_W'(1);
            if (half_hit)          half_q <= 1'b1;
            if (left_q == ONE)     full_q <= 1'b1;
        end
    end

    assign left      = left_q;
    assign cursor    = cur_q;
    assign half_flag = half_q;
    assign full_flag = full_q;
    assign early     = step && (left_q == TWO);
    assign final_x   = step && (left_q == ONE);

    // R4: the pointer advances by exactly one per step
    a_r4_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start) |=> (cur_q == $past(cur_q) + ADDR_W'(1)));

    // R8: full flag never sets while bytes remain
    a_r8_full_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> (left_q == '0));
endmodule

// File: rtl/dma_chan_top.sv
// Top level of one byte-mover channel.
// Connects the register file, the bus sequencer and the progress tracker.
// The channel is active while it is enabled and bytes remain.
// Assumes a single-beat bus with one ack per access and a level request from the peripheral.
module dma_chan_top
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [1:0]        chan_prio,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic              eot_early,
    output logic              eot_final,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic [CNT_W-1:0]  xfer_left,
    output logic              half_flag,
    output logic              full_flag,
    output logic              irq
);
    logic [ADDR_W-1:0] paddr, maddr, cursor;
    logic [CNT_W-1:0]  count;
    ctrl_t             ctrl;
    logic              start, step, active;

    dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .paddr(paddr), .maddr(maddr), .count(count),
        .ctrl(ctrl), .start(start)
    );

    dma_progress #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_prog (
        .clk(clk), .rst_n(rst_n), .start(start), .count(count), .maddr(maddr),
        .step(step), .left(xfer_left), .cursor(cursor), .half_flag(half_flag),
        .full_flag(full_flag), .early(eot_early), .final_x(eot_final)
    );

    assign active = ctrl.en && (xfer_left != '0);

    dma_xfer_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .periph_req(periph_req),
        .dir(ctrl.dir), .paddr(paddr), .cursor(cursor), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .step(step)
    );

    assign periph_ack = step;
    assign chan_prio  = ctrl.prio;
    assign irq        = (half_flag && ctrl.half_ie) || (full_flag && ctrl.full_ie);

    // R5: each acknowledgement removes exactly one byte from the count
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |=> (xfer_left == $past(xfer_left) - CNT_W'(1)));

    // R5: the acknowledgement is a single-cycle pulse
    a_r5_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |=> !periph_ack);

    // R7: the final strobe leaves the count at zero
    a_r7_final_empties: assert property (@(posedge clk) disable iff (!rst_n)
        eot_final |=> (xfer_left == '0));

    // R6: the two end strobes never coincide
    a_r6_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(eot_early && eot_final));

    // R9: an exhausted channel keeps the bus idle
    a_r9_quiet_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((xfer_left == '0) && !bus_req) |=> !bus_req);

    // R8: an interrupt needs a raised flag
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (half_flag || full_flag));
endmodule

// File: tb/sim_dma_chan_top.sv
module sim_dma_chan_top;
    localparam logic [31:0] PADDR = 32'h4000_0010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  chan_prio;
    logic        periph_req = 1'b0;
    logic        periph_ack, eot_early, eot_final;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic [15:0] xfer_left;
    logic        half_flag, full_flag, irq;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0]  mem [0:255];
    logic [7:0]  periph_src = '0;
    logic [7:0]  periph_dst = '0;
    int          n_rd = 0, n_wr = 0;
    logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
    logic [7:0]  last_wdata = '0;

    always #4 clk = ~clk;

    dma_chan_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .chan_prio(chan_prio), .periph_req(periph_req),
        .periph_ack(periph_ack), .eot_early(eot_early), .eot_final(eot_final),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .xfer_left(xfer_left), .half_flag(half_flag), .full_flag(full_flag), .irq(irq)
    );

    // Bus slave model: acknowledges each access at a falling edge and logs it.
    always @(negedge clk) begin
        if (bus_req && !bus_ack) begin
            bus_ack = 1'b1;
            if (bus_we) begin
                n_wr++;
                last_wr_addr = bus_addr;
                last_wdata = bus_wdata;
                if (bus_addr == PADDR) periph_dst = bus_wdata;
                else mem[bus_addr[7:0]] = bus_wdata;
            end else begin
                n_rd++;
                last_rd_addr = bus_addr;
                bus_rdata = (bus_addr == PADDR) ? periph_src : mem[bus_addr[7:0]];
            end
        end else begin
            bus_ack = 1'b0;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(logic [1:0] sel, logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Control word: bit0 en, bit1 dir, bit2 half ie, bit3 full ie, bits5:4 prio.
    function automatic logic [31:0] ctl(bit en, bit dir, bit hie, bit fie, logic [1:0] pr);
        return {26'd0, pr, fie, hie, dir, en};
    endfunction

    task automatic start_run(logic [31:0] ma, logic [15:0] cnt, logic [31:0] cw);
        wr_cfg(2'd3, 32'd0);
        wr_cfg(2'd0, PADDR);
        wr_cfg(2'd1, ma);
        wr_cfg(2'd2, {16'd0, cnt});
        wr_cfg(2'd3, cw);
        @(negedge clk);
    endtask

    // Raise one request, wait for the ack and capture the strobes seen with it.
    task automatic serve(output bit got_ack, output bit e, output bit f);
        got_ack = 0; e = 0; f = 0;
        periph_req = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (periph_ack) begin
                got_ack = 1; e = eot_early; f = eot_final;
                break;
            end
        end
        periph_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle_req(string tag);
        int rd0 = n_rd, wr0 = n_wr, acks = 0;
        periph_req = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (periph_ack) acks++;
        end
        periph_req = 1'b0;
        @(negedge clk);
        chk({tag, " bus accesses"}, (n_rd - rd0) + (n_wr - wr0), 0);
        chk({tag, " acks"}, acks, 0);
    endtask

    task automatic t_reset;
        chk("R1 bus_req", bus_req, 0);
        chk("R1 periph_ack", periph_ack, 0);
        chk("R1 strobes", {eot_early, eot_final}, 0);
        chk("R1 flags/irq", {half_flag, full_flag, irq}, 0);
        chk("R1 xfer_left", xfer_left, 0);
    endtask

    task automatic t_disabled;
        wr_cfg(2'd0, PADDR);
        wr_cfg(2'd2, 32'd5);
        idle_req("R12 disabled");
    endtask

    task automatic t_p2m_four;
        bit a, e, f;
        start_run(32'h20, 16'd4, ctl(1, 0, 1, 1, 2'd0));
        chk("R2 loaded count", xfer_left, 4);
        for (int i = 0; i < 4; i++) begin
            periph_src = 8'hA0 + 8'(i);
            serve(a, e, f);
            chk("R5 ack seen", a, 1);
            chk("R3 read addr periph", last_rd_addr, PADDR);
            chk("R4 write addr advances", last_wr_addr, 32'h20 + i);
            chk("R3 data moved", mem[8'h20 + 8'(i)], 8'hA0 + i);
            chk("R5 count down", xfer_left, 3 - i);
            chk("R6 early strobe", e, (i == 2) ? 1 : 0);
            chk("R7 final strobe", f, (i == 3) ? 1 : 0);
            chk("R8 half flag even", half_flag, (i >= 1) ? 1 : 0);
            chk("R8 full flag", full_flag, (i == 3) ? 1 : 0);
            chk("R8 irq half enabled", irq, (i >= 1) ? 1 : 0);
        end
        chk("R3 one read one write each", n_rd * 16 + n_wr, 4 * 16 + 4);
        idle_req("R9 exhausted");
        chk("R9 count stays zero", xfer_left, 0);
    endtask

    task automatic t_m2p_three;
        bit a, e, f;
        int rd0, wr0;
        for (int i = 0; i < 3; i++) mem[8'h40 + 8'(i)] = 8'h5A ^ 8'(i);
        start_run(32'h40, 16'd3, ctl(1, 1, 0, 1, 2'd2));
        chk("R2 flags cleared on start", {half_flag, full_flag}, 0);
        chk("R11 priority", chan_prio, 2);
        wr_cfg(2'd2, 32'd9);
        wr_cfg(2'd1, 32'h80);
        wr_cfg(2'd3, ctl(1, 0, 1, 1, 2'd1));
        chk("R10 count write ignored", xfer_left, 3);
        chk("R10 priority frozen", chan_prio, 2);
        rd0 = n_rd; wr0 = n_wr;
        for (int i = 0; i < 3; i++) begin
            serve(a, e, f);
            chk("R3 read from buffer", last_rd_addr, 32'h40 + i);
            chk("R3 write to periph", last_wr_addr, PADDR);
            chk("R3 periph got byte", periph_dst, 8'h5A ^ i);
            chk("R6 early on count 3", e, (i == 1) ? 1 : 0);
            chk("R7 final on count 3", f, (i == 2) ? 1 : 0);
            chk("R8 half flag odd", half_flag, (i >= 1) ? 1 : 0);
            chk("R8 irq full only", irq, (i == 2) ? 1 : 0);
        end
        chk("R3 access count", (n_rd - rd0) * 16 + (n_wr - wr0), 3 * 16 + 3);
    endtask

    task automatic t_single;
        bit a, e, f;
        periph_src = 8'h3C;
        start_run(32'h90, 16'd1, ctl(1, 0, 1, 0, 2'd3));
        chk("R2 restart clears full", full_flag, 0);
        serve(a, e, f);
        chk("R6 no early on single", e, 0);
        chk("R7 final on single", f, 1);
        chk("R8 half with single", half_flag, 1);
        chk("R8 full with single", full_flag, 1);
        chk("R4 single write addr", last_wr_addr, 32'h90);
    endtask

    task automatic t_zero_count;
        start_run(32'hA0, 16'd0, ctl(1, 0, 1, 1, 2'd1));
        chk("R9 zero start count", xfer_left, 0);
        chk("R11 priority follows", chan_prio, 1);
        idle_req("R9 zero count");
        chk("R9 no flags after zero", {half_flag, full_flag}, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_disabled();
        t_p2m_four();
        t_m2p_three();
        t_single();
        t_zero_count();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule